// File: doc/BRIEF.md
# Decade Johnson Counter with Decoded Outputs

This block counts in tens. Its state sits in a five-stage twisted-ring (Johnson) register, which steps through ten codes in each cycle. Each code is decoded into one of ten one-hot slot lines, and a carry line is also produced. Each slot line is formed from only two adjacent register bits, so no decoding glitches appear when the state changes. The carry is high for the first half of each decade and low for the second half. It is therefore a square wave at one tenth of the count rate.

The count clock, the inhibit and the counter reset are slow external levels, and none of them clocks a flip-flop. Each passes through a two-flop synchronizer into the fast system clock `clk_i`. The block advances on a rising edge of (count clock AND NOT inhibit). A modified feedback term in the register steers every illegal code back into the ten-state ring. The system reset loads a parameterised power-up code, which may be illegal, so that this recovery can be used.

Top module: `decade_ring_div`

## Requirements
- R1: Each advance event moves the single high slot from slot k to slot (k+1) mod 10, so slot 9 is followed by slot 0.
- R2: An advance event is a rising edge of cnt_clk_i while inhibit_i is low. Count-clock edges that occur while inhibit_i is high leave the outputs unchanged.
- R3: If inhibit_i falls while cnt_clk_i is high, the counter advances exactly once. If inhibit_i rises, or cnt_clk_i falls, the counter does not advance.
- R4: While cnt_clk_i is low, a high level on inhibit_i, or a change on inhibit_i, produces no advance.
- R5: While the count is in the legal ring, exactly one of the ten slot_o bits is high. Bit k of slot_o is high in count k.
- R6: carry_o is 1 while slot 0, 1, 2, 3 or 4 is high, and 0 while slot 5, 6, 7, 8 or 9 is high.
- R7: A high reset_i forces count 0: slot_o = 10'b0000000001 and carry_o = 1. While reset_i stays high, count-clock edges have no effect.
- R8: An input change takes effect at the third rising edge of clk_i after it is applied. Before that edge the outputs are unchanged.
- R9: After rst_ni is released, the register holds INIT_CODE. With the default code 5'b00000, the outputs show count 0.
- R10: From any of the 32 possible register codes, the outputs are in the legal ring after at most 20 advance events, and they then follow the R1 sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples all inputs |
| rst_ni | input | 1 | Asynchronous active-low system reset; loads INIT_CODE |
| cnt_clk_i | input | 1 | Count clock level, asynchronous to clk_i |
| inhibit_i | input | 1 | Active-high count inhibit, asynchronous |
| reset_i | input | 1 | Active-high counter clear, asynchronous |
| slot_o | output | 10 | One-hot decoded count; bit k is high in count k |
| carry_o | output | 1 | High for counts 0 to 4, low for counts 5 to 9 |

## Verification
The hardest situation to reach from the ports is a register that holds one of the 22 illegal codes, because the count logic alone never enters one. The bench therefore builds 32 extra instances, each with a different INIT_CODE, and drives them all with the same count-clock pulses. After 20 advances every instance must show a one-hot slot whose carry matches it, and one further pulse must rotate that slot by one. The advance that comes from inhibit falling while the count clock is already high is reached by raising the count clock under inhibit first and then releasing inhibit alone.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int unsigned NSTAGE = 5;
  localparam int unsigned NSLOT  = 2 * NSTAGE;
  typedef logic [NSTAGE-1:0] ring_t;
  typedef logic [NSLOT-1:0]  slot_t;
endpackage

// File: rtl/decade_sync.sv
module decade_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/decade_advance.sv
module decade_advance (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_clk_i,
  input  logic inhibit_i,
  output logic advance_o
);
  logic gate, gate_q;

  // Gated clock level; its rising edge covers both the clock rising and inhibit falling.
  assign gate = cnt_clk_i & ~inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate;
  end

  assign advance_o = gate & ~gate_q;
endmodule

// File: rtl/decade_ring.sv
module decade_ring
  import decade_pkg::*;
#(
  parameter ring_t INIT_CODE = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  logic  clr_i,
  output ring_t q_o
);
  ring_t nxt;

  always_comb begin
    nxt    = {q_o[NSTAGE-2:0], ~q_o[NSTAGE-1]};
    // Anti-lock term: a lone 1 at bit 1 is not carried forward, which breaks illegal rings.
    nxt[2] = q_o[1] & (q_o[0] | q_o[2]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= INIT_CODE;
    else if (clr_i) q_o <= '0;
    else if (adv_i) q_o <= nxt;
  end
endmodule

// File: rtl/decade_decode.sv
module decade_decode
  import decade_pkg::*;
(
  input  ring_t q_i,
  output slot_t slot_o,
  output logic  carry_o
);
  assign slot_o[0]      = ~q_i[NSTAGE-1] & ~q_i[0];
  assign slot_o[NSTAGE] =  q_i[NSTAGE-1] &  q_i[0];

  for (genvar k = 1; k < NSTAGE; k++) begin : g_pair
    assign slot_o[k]        =  q_i[k-1] & ~q_i[k];
    assign slot_o[NSTAGE+k] = ~q_i[k-1] &  q_i[k];
  end

  assign carry_o = ~q_i[NSTAGE-1];
endmodule

// File: rtl/decade_ring_div.sv
module decade_ring_div
  import decade_pkg::*;
#(
  parameter ring_t INIT_CODE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_clk_i,
  input  logic             inhibit_i,
  input  logic             reset_i,
  output logic [NSLOT-1:0] slot_o,
  output logic             carry_o
);
  logic [2:0] raw_in, sync_in;
  logic       clr_s, advance;
  ring_t      ring_q;

  assign raw_in = {reset_i, inhibit_i, cnt_clk_i};

  decade_sync #(.WIDTH(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign clr_s = sync_in[2];

  decade_advance u_adv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_clk_i(sync_in[0]),
    .inhibit_i(sync_in[1]),
    .advance_o(advance)
  );

  decade_ring #(.INIT_CODE(INIT_CODE)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (advance),
    .clr_i (clr_s),
    .q_o   (ring_q)
  );

  decade_decode u_dec (
    .q_i    (ring_q),
    .slot_o (slot_o),
    .carry_o(carry_o)
  );
endmodule

// File: rtl/decade_ring_div_chk.sv
module decade_ring_div_chk
  import decade_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adv_i,
  input logic             clr_i,
  input logic [NSLOT-1:0] slot_i,
  input logic             carry_i
);
  logic seen_legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_legal <= 1'b0;
    else if ($onehot(slot_i)) seen_legal <= 1'b1;
  end

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (slot_i == NSLOT'(1)) && carry_i);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(slot_i) && $stable(carry_i));

  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_legal |-> $onehot(slot_i));

  p_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_legal |-> (carry_i == |slot_i[NSTAGE-1:0]));

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_legal && adv_i && !clr_i) |=>
      slot_i == {$past(slot_i[NSLOT-2:0]), $past(slot_i[NSLOT-1])});
endmodule

bind decade_ring_div decade_ring_div_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .adv_i  (advance),
  .clr_i  (clr_s),
  .slot_i (slot_o),
  .carry_i(carry_o)
);

// File: tb/decade_ring_div_test.sv
`timescale 1ns/1ps
module decade_ring_div_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_clk = 1'b0;
  logic inhibit = 1'b0;
  logic clr = 1'b0;
  logic [9:0] slot;
  logic carry;
  logic [9:0] rec_slot [32];
  logic       rec_carry [32];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  decade_ring_div uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .inhibit_i(inhibit),
    .reset_i(clr), .slot_o(slot), .carry_o(carry)
  );

  // R10: one instance per possible power-up code
  for (genvar c = 0; c < 32; c++) begin : g_rec
    decade_ring_div #(.INIT_CODE(5'(c))) u_rec (
      .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .inhibit_i(inhibit),
      .reset_i(clr), .slot_o(rec_slot[c]), .carry_o(rec_carry[c])
    );
  end

  task automatic check(input bit ok, input string req, input logic [9:0] act,
                       input logic [9:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    cnt_clk = 1'b1; wait_n(4);
    cnt_clk = 1'b0; wait_n(4);
  endtask

  task automatic push(input int idx, input string tag);
    exp_q.push_back(idx);
    tag_q.push_back(tag);
    wait_n(2);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int idx;
      string tag;
      logic [9:0] e;
      idx = exp_q.pop_front();
      tag = tag_q.pop_front();
      e = 10'b1 << idx;
      check(slot == e, tag, slot, e);
      check(carry == (idx < 5), {tag, " carry"}, {9'b0, carry}, {9'b0, 1'(idx < 5)});
    end
  end

  function automatic int slot_index(input logic [9:0] s);
    for (int i = 0; i < 10; i++) if (s == (10'b1 << i)) return i;
    return -1;
  endfunction

  initial begin
    int cur;
    int prev [32];
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    push(0, "R9 init code");

    // R10: recovery from all codes
    for (int p = 0; p < 20; p++) pulse();
    for (int c = 0; c < 32; c++) begin
      prev[c] = slot_index(rec_slot[c]);
      check(prev[c] >= 0, "R10 one-hot after 20 advances", rec_slot[c], 10'b0);
      check(rec_carry[c] == |rec_slot[c][4:0], "R10 carry consistent",
            {9'b0, rec_carry[c]}, {9'b0, |rec_slot[c][4:0]});
    end
    pulse();
    for (int c = 0; c < 32; c++) begin
      logic [9:0] e;
      e = (prev[c] >= 0) ? (10'b1 << ((prev[c] + 1) % 10)) : 10'b0;
      check(rec_slot[c] == e, "R10 sequence after recovery", rec_slot[c], e);
    end

    // R7: clear from count 1
    clr = 1'b1; wait_n(4);
    push(0, "R7 clear");
    clr = 1'b0; wait_n(4);

    // R1 R5 R6: full decade
    for (int i = 1; i <= 10; i++) begin
      pulse();
      push(i % 10, "R1 R5 R6 step");
    end

    // R8: latency of three clk_i edges
    cnt_clk = 1'b1;
    wait_n(2);
    check(slot == 10'b1, "R8 unchanged before third edge", slot, 10'b1);
    wait_n(1);
    check(slot == 10'b10, "R8 changed at third edge", slot, 10'b10);
    wait_n(2);
    cnt_clk = 1'b0; wait_n(4);
    cur = 1;

    // R2: clock edges under inhibit
    inhibit = 1'b1; wait_n(4);
    for (int p = 0; p < 3; p++) pulse();
    push(cur, "R2 inhibit holds");

    // R3: inhibit falls while clock high
    cnt_clk = 1'b1; wait_n(4);
    push(cur, "R3 clock rise under inhibit");
    inhibit = 1'b0; wait_n(4);
    cur++;
    push(cur, "R3 inhibit fall advances");
    inhibit = 1'b1; wait_n(4);
    push(cur, "R3 inhibit rise no advance");
    cnt_clk = 1'b0; wait_n(4);
    push(cur, "R3 clock fall no advance");
    // R4: inhibit toggling with clock low
    inhibit = 1'b0; wait_n(4);
    push(cur, "R4 inhibit fall clock low");
    inhibit = 1'b1; wait_n(4);
    inhibit = 1'b0; wait_n(4);
    push(cur, "R4 inhibit pulse clock low");

    // R7: reset overrides clock
    for (int p = 0; p < 5; p++) pulse();
    push(7, "R1 before clear");
    clr = 1'b1; wait_n(4);
    pulse(); pulse();
    push(0, "R7 clock ignored during clear");
    clr = 1'b0; wait_n(4);
    pulse();
    push(1, "R7 count resumes");

    wait (exp_q.size() == 0);
    wait_n(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule